// File: doc/BRIEF.md
# Streaming Mode Control Register

This block is a 64-bit privileged control register holding two live state bits: a flag that puts the vector unit into streaming mode, and an enable for the matrix storage array. Software reaches it through two write paths. The register form replaces the whole value from a data word. The immediate form names one or both bits in its encoding and writes a single value bit to them. A register-form read returns the current state at once, with the reserved bits zero.

Every write compares each bit's old and new values and raises one-cycle side-effect pulses for the neighbouring units. The pulses are clear matrix storage, clear the vector register file of the new mode, clear the FP mode register, and load the FP status register with a fixed value. The block also turns instruction-class flags from the decoder into trap syndromes when an instruction does not fit the current mode or storage state. Privilege checks and the register files themselves sit outside the block.

Top module: `strm_ctl_reg`

## Requirements
- R1: After reset both state bits are 0, a register-form read returns 0, and all four side-effect pulses are low.
- R2: A register-form read (acc_write=0, op0=11, op1=011, CRn=0100, CRm=0010, op2=010) sets acc_hit in the same cycle. rd_data then carries the streaming flag in bit 0 and the storage enable in bit 1, and bits 63:2 are zero.
- R3: A register-form write (same encoding, acc_write=1) loads bit 0 and bit 1 of acc_wdata into the streaming flag and storage enable and ignores the other bits. A read in the very next cycle returns the new value.
- R4: An immediate-form write (op0=00, op1=011, CRn=0100, op2=011) uses CRm[3:1] to pick its target: 001 for the streaming flag alone, 010 for the storage enable alone, 011 for both. It writes CRm[0] to each bit it picks and leaves the other bit unchanged.
- R5: An access with any other encoding has no effect. This covers an immediate form whose CRm[3:1] is not 001, 010 or 011, an immediate form with acc_write=0, and a deasserted acc_valid. Such an access leaves the state unchanged, raises no pulse, and gives acc_hit=0 and rd_data=0.
- R6: clr_matrix_o is high for exactly the one cycle after a write that takes the storage enable from 0 to 1. A 1-to-0 change, or a write that leaves the enable unchanged, raises no pulse.
- R7: A write that changes the streaming flag in either direction raises clr_vec_o, clr_fpmr_o and ld_fpsr_o together for exactly the one cycle after the write. A write that leaves the flag unchanged raises none of them. fpsr_val_o is always 0x0000_0000_0800_009F.
- R8: A change of the streaming flag alone does not raise clr_matrix_o. A change of the storage enable alone raises none of clr_vec_o, clr_fpmr_o or ld_fpsr_o.
- R9: When chk_valid is high, the syndrome subcode is chosen as follows, and the mode checks take priority over the storage check:
  - subcode 1 when streaming and chk_stream_bad is set;
  - otherwise subcode 2 when not streaming and chk_stream_need is set;
  - otherwise subcode 3 when the storage is disabled and chk_store_use is set.

  A raised trap reports class 0x1D. With no trap, trap_o, trap_class_o and trap_sub_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| acc_valid | input | 1 | System register access present this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm (target select and immediate value for the immediate form) |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | 64 | Register-form write data |
| acc_hit | output | 1 | Access decoded as a valid read or write of this register |
| rd_data | output | 64 | Read data, zero unless a register-form read hits |
| mode_o | output | 1 | Streaming flag |
| store_en_o | output | 1 | Matrix storage enable |
| clr_matrix_o | output | 1 | Pulse: clear matrix storage |
| clr_vec_o | output | 1 | Pulse: clear vector, predicate and first-fault registers of the new mode |
| clr_fpmr_o | output | 1 | Pulse: clear FP mode register |
| ld_fpsr_o | output | 1 | Pulse: load FP status register with fpsr_val_o |
| fpsr_val_o | output | 64 | Value loaded into the FP status register |
| chk_valid | input | 1 | Instruction presented for a mode check |
| chk_store_use | input | 1 | Instruction accesses matrix storage |
| chk_stream_bad | input | 1 | Instruction is illegal in streaming mode |
| chk_stream_need | input | 1 | Instruction is legal only in streaming mode |
| trap_o | output | 1 | Trap raised |
| trap_class_o | output | 6 | Trap class |
| trap_sub_o | output | 2 | Trap subcode |

## Verification
The assertions check several properties on every cycle:
- a matrix-clear pulse only follows a rise of the enable and never lasts two cycles;
- every change of the streaming flag brings the three vector-side pulses;
- state holds when no write is decoded, and a register-form write loads exactly its two low data bits;
- a storage-disabled syndrome never appears while the storage is enabled.

Only the bench's scenarios show the rest. These are the exact pulse patterns for each immediate target, the absence of pulses on unchanged or one-sided writes, the rejection of near-miss encodings, the same-cycle read after a write, and the subcode priority when several instruction flags are raised at once.

// File: rtl/strm_pkg.sv
package strm_pkg;

   // register-form access encoding
   localparam logic [1:0] ENC_OP0_REG = 2'b11;
   localparam logic [2:0] ENC_OP2_REG = 3'b010;
   localparam logic [3:0] ENC_CRM_REG = 4'b0010;
   // immediate-form access encoding
   localparam logic [1:0] ENC_OP0_IMM = 2'b00;
   localparam logic [2:0] ENC_OP2_IMM = 3'b011;
   // fields shared by both forms
   localparam logic [2:0] ENC_OP1     = 3'b011;
   localparam logic [3:0] ENC_CRN     = 4'b0100;

   // immediate target selectors, taken from CRm[3:1]
   localparam logic [2:0] TGT_MODE = 3'b001;
   localparam logic [2:0] TGT_EN   = 3'b010;
   localparam logic [2:0] TGT_BOTH = 3'b011;

   typedef struct packed {
      logic en;    // bit 1: matrix storage enable
      logic mode;  // bit 0: streaming flag
   } ctl_t;

   typedef enum logic [1:0] {
      SUB_NONE        = 2'd0,
      SUB_STREAM_BAD  = 2'd1,
      SUB_STREAM_NEED = 2'd2,
      SUB_STORE_OFF   = 2'd3
   } trap_sub_e;

endpackage

// File: rtl/strm_acc_decode.sv
module strm_acc_decode
   import strm_pkg::*;
(
   input  logic       valid_i,
   input  logic       write_i,
   input  logic [1:0] op0_i,
   input  logic [2:0] op1_i,
   input  logic [3:0] crn_i,
   input  logic [3:0] crm_i,
   input  logic [2:0] op2_i,
   output logic       reg_rd_o,
   output logic       reg_wr_o,
   output logic       imm_wr_o,
   output logic       imm_mode_o,
   output logic       imm_en_o,
   output logic       imm_val_o
);

   logic common_hit;
   logic reg_enc;
   logic imm_enc;
   logic tgt_ok;

   assign common_hit = (op1_i == ENC_OP1) && (crn_i == ENC_CRN);
   assign reg_enc    = common_hit && (op0_i == ENC_OP0_REG) &&
                       (crm_i == ENC_CRM_REG) && (op2_i == ENC_OP2_REG);
   assign tgt_ok     = (crm_i[3:1] == TGT_MODE) || (crm_i[3:1] == TGT_EN) ||
                       (crm_i[3:1] == TGT_BOTH);
   assign imm_enc    = common_hit && (op0_i == ENC_OP0_IMM) &&
                       (op2_i == ENC_OP2_IMM) && tgt_ok;

   assign reg_rd_o   = valid_i && !write_i && reg_enc;
   assign reg_wr_o   = valid_i &&  write_i && reg_enc;
   assign imm_wr_o   = valid_i &&  write_i && imm_enc;
   // among the legal selectors, CRm[1] names the flag and CRm[2] the enable
   assign imm_mode_o = crm_i[1];
   assign imm_en_o   = crm_i[2];
   assign imm_val_o  = crm_i[0];

endmodule

// File: rtl/strm_state_reg.sv
module strm_state_reg
   import strm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic reg_wr_i,
   input  ctl_t reg_val_i,
   input  logic imm_wr_i,
   input  logic imm_mode_i,
   input  logic imm_en_i,
   input  logic imm_val_i,
   output ctl_t cur_o,
   output logic clr_matrix_o,
   output logic clr_vec_o,
   output logic clr_fpmr_o,
   output logic ld_fpsr_o
);

   ctl_t nxt;

   always_comb begin
      nxt = cur_o;
      if (reg_wr_i) begin
         nxt = reg_val_i;
      end else if (imm_wr_i) begin
         if (imm_mode_i) nxt.mode = imm_val_i;
         if (imm_en_i)   nxt.en   = imm_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_o        <= '0;
         clr_matrix_o <= 1'b0;
         clr_vec_o    <= 1'b0;
         clr_fpmr_o   <= 1'b0;
         ld_fpsr_o    <= 1'b0;
      end else begin
         cur_o        <= nxt;
         clr_matrix_o <= !cur_o.en && nxt.en;
         clr_vec_o    <= cur_o.mode ^ nxt.mode;
         clr_fpmr_o   <= cur_o.mode ^ nxt.mode;
         ld_fpsr_o    <= cur_o.mode ^ nxt.mode;
      end
   end

   // R6
   matrix_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_matrix_o |-> (cur_o.en && !$past(cur_o.en)));

   // R6
   matrix_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_matrix_o |=> !clr_matrix_o);

   // R7
   mode_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_o.mode != $past(cur_o.mode)) |-> (clr_vec_o && clr_fpmr_o && ld_fpsr_o));

   // R8
   vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_o.mode == $past(cur_o.mode)) |-> !(clr_vec_o || clr_fpmr_o || ld_fpsr_o));

endmodule

// File: rtl/strm_trap_gen.sv
module strm_trap_gen
   import strm_pkg::*;
#(
   parameter int                 CLASS_W    = 6,
   parameter int                 SUB_W      = 2,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h1D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  ctl_t               cur_i,
   input  logic               chk_valid_i,
   input  logic               store_use_i,
   input  logic               stream_bad_i,
   input  logic               stream_need_i,
   output logic               trap_o,
   output logic [CLASS_W-1:0] class_o,
   output logic [SUB_W-1:0]   sub_o
);

   trap_sub_e sel;

   always_comb begin
      sel = SUB_NONE;
      if (chk_valid_i) begin
         if (cur_i.mode && stream_bad_i)        sel = SUB_STREAM_BAD;
         else if (!cur_i.mode && stream_need_i) sel = SUB_STREAM_NEED;
         else if (!cur_i.en && store_use_i)     sel = SUB_STORE_OFF;
      end
   end

   assign trap_o  = (sel != SUB_NONE);
   assign class_o = trap_o ? TRAP_CLASS : '0;

   generate
      if (SUB_W > 2) begin : g_sub_wide
         assign sub_o = {{(SUB_W-2){1'b0}}, sel};
      end else begin : g_sub_exact
         assign sub_o = sel;
      end
   endgenerate

   // R9
   store_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_o && (sub_o == SUB_W'(3))) |-> !cur_i.en);

   // R9
   idle_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid_i |-> !trap_o);

endmodule

// File: rtl/strm_ctl_reg.sv
module strm_ctl_reg
   import strm_pkg::*;
#(
   parameter int                 DATA_W     = 64,
   parameter int                 CLASS_W    = 6,
   parameter int                 SUB_W      = 2,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h1D,
   parameter logic [DATA_W-1:0]  FPSR_INIT  = 64'h0000_0000_0800_009F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [1:0]         acc_op0,
   input  logic [2:0]         acc_op1,
   input  logic [3:0]         acc_crn,
   input  logic [3:0]         acc_crm,
   input  logic [2:0]         acc_op2,
   input  logic [DATA_W-1:0]  acc_wdata,
   output logic               acc_hit,
   output logic [DATA_W-1:0]  rd_data,
   output logic               mode_o,
   output logic               store_en_o,
   output logic               clr_matrix_o,
   output logic               clr_vec_o,
   output logic               clr_fpmr_o,
   output logic               ld_fpsr_o,
   output logic [DATA_W-1:0]  fpsr_val_o,
   input  logic               chk_valid,
   input  logic               chk_store_use,
   input  logic               chk_stream_bad,
   input  logic               chk_stream_need,
   output logic               trap_o,
   output logic [CLASS_W-1:0] trap_class_o,
   output logic [SUB_W-1:0]   trap_sub_o
);

   localparam int RSV_W = DATA_W - 2;

   generate
      if (DATA_W < 3)  begin : g_bad_data_w  $error("DATA_W must exceed 2");  end
      if (SUB_W < 2)   begin : g_bad_sub_w   $error("SUB_W must be at least 2"); end
      if (CLASS_W < 6) begin : g_bad_class_w $error("CLASS_W must be at least 6"); end
   endgenerate

   logic reg_rd, reg_wr, imm_wr, imm_mode, imm_en, imm_val;
   ctl_t cur;
   ctl_t wr_val;
   logic unused_wdata;

   strm_acc_decode u_dec (
      .valid_i    (acc_valid),
      .write_i    (acc_write),
      .op0_i      (acc_op0),
      .op1_i      (acc_op1),
      .crn_i      (acc_crn),
      .crm_i      (acc_crm),
      .op2_i      (acc_op2),
      .reg_rd_o   (reg_rd),
      .reg_wr_o   (reg_wr),
      .imm_wr_o   (imm_wr),
      .imm_mode_o (imm_mode),
      .imm_en_o   (imm_en),
      .imm_val_o  (imm_val)
   );

   assign wr_val.en     = acc_wdata[1];
   assign wr_val.mode   = acc_wdata[0];
   assign unused_wdata  = ^acc_wdata[DATA_W-1:2];

   strm_state_reg u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr_i     (reg_wr),
      .reg_val_i    (wr_val),
      .imm_wr_i     (imm_wr),
      .imm_mode_i   (imm_mode),
      .imm_en_i     (imm_en),
      .imm_val_i    (imm_val),
      .cur_o        (cur),
      .clr_matrix_o (clr_matrix_o),
      .clr_vec_o    (clr_vec_o),
      .clr_fpmr_o   (clr_fpmr_o),
      .ld_fpsr_o    (ld_fpsr_o)
   );

   strm_trap_gen #(
      .CLASS_W    (CLASS_W),
      .SUB_W      (SUB_W),
      .TRAP_CLASS (TRAP_CLASS)
   ) u_trap (
      .clk           (clk),
      .rst_n         (rst_n),
      .cur_i         (cur),
      .chk_valid_i   (chk_valid),
      .store_use_i   (chk_store_use),
      .stream_bad_i  (chk_stream_bad),
      .stream_need_i (chk_stream_need),
      .trap_o        (trap_o),
      .class_o       (trap_class_o),
      .sub_o         (trap_sub_o)
   );

   assign acc_hit    = reg_rd || reg_wr || imm_wr;
   assign rd_data    = reg_rd ? {{RSV_W{1'b0}}, cur.en, cur.mode} : '0;
   assign mode_o     = cur.mode;
   assign store_en_o = cur.en;
   assign fpsr_val_o = FPSR_INIT;

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr || imm_wr) |=> (mode_o == $past(mode_o)) && (store_en_o == $past(store_en_o)));

   // R3
   reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (mode_o == $past(acc_wdata[0])) && (store_en_o == $past(acc_wdata[1])));

endmodule

// File: tb/strm_ctl_reg_tb.sv
module strm_ctl_reg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [1:0]  acc_op0 = '0;
   logic [2:0]  acc_op1 = '0, acc_op2 = '0;
   logic [3:0]  acc_crn = '0, acc_crm = '0;
   logic [63:0] acc_wdata = '0;
   logic        acc_hit;
   logic [63:0] rd_data, fpsr_val_o;
   logic        mode_o, store_en_o, clr_matrix_o, clr_vec_o, clr_fpmr_o, ld_fpsr_o;
   logic        chk_valid = 1'b0, chk_store_use = 1'b0;
   logic        chk_stream_bad = 1'b0, chk_stream_need = 1'b0;
   logic        trap_o;
   logic [5:0]  trap_class_o;
   logic [1:0]  trap_sub_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   strm_ctl_reg u_dut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // pulse vector {matrix, vec, fpmr, fpsr}
   function automatic logic [3:0] pulses();
      return {clr_matrix_o, clr_vec_o, clr_fpmr_o, ld_fpsr_o};
   endfunction

   // drive one access at a negedge; return at the next negedge with it removed
   task automatic access(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                         input logic [3:0] cm, input logic [2:0] o2, input logic wr,
                         input logic [63:0] wd);
      acc_valid = 1'b1; acc_write = wr; acc_op0 = o0; acc_op1 = o1;
      acc_crn = cn; acc_crm = cm; acc_op2 = o2; acc_wdata = wd;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
   endtask

   task automatic reg_wr(input logic [63:0] wd);
      access(2'b11, 3'b011, 4'b0100, 4'b0010, 3'b010, 1'b1, wd);
   endtask

   task automatic imm_wr(input logic [3:0] cm);
      access(2'b00, 3'b011, 4'b0100, cm, 3'b011, 1'b1, '0);
   endtask

   // register-form read, sampled within the current cycle
   task automatic reg_rd(input string tag, input logic [63:0] exp);
      acc_valid = 1'b1; acc_write = 1'b0; acc_op0 = 2'b11; acc_op1 = 3'b011;
      acc_crn = 4'b0100; acc_crm = 4'b0010; acc_op2 = 3'b010;
      #1;
      chk({tag, " rd_hit"}, 64'(acc_hit), 64'd1);
      chk({tag, " rd_data"}, rd_data, exp);
      acc_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 mode", 64'(mode_o), 64'd0);
      chk("R1 en", 64'(store_en_o), 64'd0);
      chk("R1 pulses", 64'(pulses()), 64'd0);
      reg_rd("R1 read", 64'd0);
   endtask

   task automatic t_reg_form();
      reg_wr(64'hFFFF_FFFF_FFFF_FFFF);
      chk("R3 R6 R7 pulses on 0->3", 64'(pulses()), 64'hF);
      chk("R7 fpsr value", fpsr_val_o, 64'h0000_0000_0800_009F);
      reg_rd("R2 R3 read after write", 64'd3);
      chk("R6 R7 pulse width", 64'(pulses()), 64'd0);
      reg_wr(64'hAAAA_AAAA_AAAA_AAA8);
      chk("R6 R7 3->0 pulses", 64'(pulses()), 64'b0111);
      reg_rd("R3 upper bits ignored", 64'd0);
   endtask

   task automatic t_immediate();
      imm_wr(4'b0011);
      chk("R4 R8 mode only set pulses", 64'(pulses()), 64'b0111);
      chk("R4 mode set", 64'({store_en_o, mode_o}), 64'd1);
      imm_wr(4'b0101);
      chk("R4 R8 en only set pulses", 64'(pulses()), 64'b1000);
      chk("R4 en set", 64'({store_en_o, mode_o}), 64'd3);
      imm_wr(4'b0011);
      chk("R7 unchanged mode no pulse", 64'(pulses()), 64'd0);
      imm_wr(4'b0100);
      chk("R6 en 1->0 no clear", 64'(pulses()), 64'd0);
      chk("R4 en cleared mode kept", 64'({store_en_o, mode_o}), 64'd1);
      imm_wr(4'b0110);
      chk("R4 both clear pulses", 64'(pulses()), 64'b0111);
      imm_wr(4'b0111);
      chk("R4 both set pulses", 64'(pulses()), 64'hF);
      reg_rd("R4 both set read", 64'd3);
   endtask

   task automatic t_ignored();
      imm_wr(4'b0000);
      chk("R5 bad selector 000 pulses", 64'(pulses()), 64'd0);
      imm_wr(4'b1000);
      chk("R5 bad selector 100 pulses", 64'(pulses()), 64'd0);
      access(2'b11, 3'b011, 4'b0100, 4'b0010, 3'b011, 1'b1, '0);
      chk("R5 wrong op2 pulses", 64'(pulses()), 64'd0);
      access(2'b00, 3'b011, 4'b0100, 4'b0110, 3'b011, 1'b0, '0);
      chk("R5 imm read pulses", 64'(pulses()), 64'd0);
      acc_valid = 1'b0; acc_write = 1'b1; acc_op0 = 2'b11; acc_op1 = 3'b011;
      acc_crn = 4'b0100; acc_crm = 4'b0010; acc_op2 = 3'b010; acc_wdata = '0;
      @(negedge clk);
      acc_write = 1'b0;
      chk("R5 invalid write pulses", 64'(pulses()), 64'd0);
      reg_rd("R5 state kept", 64'd3);
      acc_valid = 1'b1; acc_write = 1'b0; acc_op0 = 2'b00; acc_op2 = 3'b011;
      acc_crm = 4'b0110;
      #1;
      chk("R5 imm read hit", 64'(acc_hit), 64'd0);
      chk("R5 imm read data", rd_data, 64'd0);
      acc_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic trap_case(input string tag, input logic v, input logic su, input logic sb,
                            input logic sn, input logic t, input logic [1:0] s);
      chk_valid = v; chk_store_use = su; chk_stream_bad = sb; chk_stream_need = sn;
      #1;
      chk({tag, " trap"}, 64'(trap_o), 64'(t));
      chk({tag, " class"}, 64'(trap_class_o), t ? 64'h1D : 64'd0);
      chk({tag, " sub"}, 64'(trap_sub_o), 64'(s));
      chk_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_traps();
      reg_wr(64'd1);
      trap_case("R9 streaming illegal", 1, 0, 1, 0, 1, 2'd1);
      trap_case("R9 priority over store", 1, 1, 1, 1, 1, 2'd1);
      trap_case("R9 need ok in streaming", 1, 0, 0, 1, 0, 2'd0);
      trap_case("R9 store off", 1, 1, 0, 0, 1, 2'd3);
      trap_case("R9 no valid", 0, 1, 1, 1, 0, 2'd0);
      reg_wr(64'd2);
      trap_case("R9 stream only", 1, 1, 0, 1, 1, 2'd2);
      trap_case("R9 store on ok", 1, 1, 1, 0, 0, 2'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg_form();
      t_immediate();
      t_ignored();
      t_traps();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule